// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned binary operands and a carry input without any clock, producing a sum vector and a carry output. It is a drop-in combinational adder for datapaths where a rippling carry chain would set the cycle time. Every carry is formed by flattened sum-of-products lookahead logic, so no carry waits on its neighbour.

The operands are cut into blocks of four bits. A bitwise stage forms per-bit generate (AND) and propagate (XOR) terms. Each block unit turns its four pairs into its three inner carries, plus a block generate and a block propagate that do not depend on the block's carry input. A second lookahead unit takes those block terms and the adder's carry input, and returns each block's carry input and the final carry. The XOR propagate term is reused by the bitwise sum stage, which forms each sum bit as propagate XOR carry.

With the width parameter equal to the block size, the same sub-units assemble into a single-level adder. In that case one lookahead unit drives every carry and the carry output directly.

Top module: `cla_adder2`

## Requirements
- R1: For every input, {c_out, sum_o} equals x_in + y_in + c_in taken as a WIDTH+1 bit unsigned sum (default WIDTH 16).
- R2: A carry that has to travel the full width arrives at c_out. With x_in all ones, y_in zero and c_in 1, sum_o is zero and c_out is 1. The same result holds for x_in all ones, y_in 1 and c_in 0.
- R3: When y_in is the bitwise inverse of x_in, every position propagates: c_out equals c_in and every bit of sum_o equals the inverse of c_in.
- R4: With both operands zero and c_in 1, sum_o is 1 and c_out is 0. With all inputs zero, both outputs are zero.
- R5: A carry generated in the top bit of one 4-bit block (bit 4k+3) enters the next block. For example, 0x0008 + 0x0008 gives 0x0010, and 0x0800 + 0x0800 gives 0x1000.
- R6: Alternating bit patterns add correctly: 0xAAAA + 0x5555 + 0 = 0x0FFFF, 0xAAAA + 0xAAAA + 0 = 0x15554, 0x5555 + 0x5555 + 1 = 0x0AAAB (values shown as {c_out, sum_o}).
- R7: With WIDTH equal to the block size (4), the single-level build satisfies R1 for all 512 input combinations.
- R8: The outputs depend on the present inputs only. They settle within the same half clock period in which the inputs change, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | WIDTH | First operand |
| y_in | input | WIDTH | Second operand |
| c_in | input | 1 | Carry input into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that enters at bit 0 and has to pass through every block propagate term and the second-level unit before it reaches c_out. Random operands almost never propagate in every position. The stimulus therefore forces that case directly, with all-ones operands against a single increment and with operand pairs that are exact inverses under both carry-in values. It also places a generated carry at each block's top bit, so that each second-level carry is exercised on its own.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Widest span one lookahead unit may cover.
  localparam int unsigned CLA_MAX_SPAN = 16;
  typedef logic [CLA_MAX_SPAN-1:0] cla_vec_t;

  // Flattened sum-of-products carry into position hi+1: every term reads
  // g, p and c0 directly; no term depends on another carry.
  function automatic logic cla_sop(input cla_vec_t g, input cla_vec_t p,
                                   input logic c0, input int unsigned hi,
                                   input logic use_c0);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int unsigned j = 0; j < CLA_MAX_SPAN; j++) begin
      if (j <= hi) begin
        term = g[j];
        for (int unsigned k = 0; k < CLA_MAX_SPAN; k++)
          if (k > j && k <= hi) term = term & p[k];
        acc = acc | term;
      end
    end
    term = c0 & use_c0;
    for (int unsigned k = 0; k < CLA_MAX_SPAN; k++)
      if (k <= hi) term = term & p[k];
    return acc | term;
  endfunction
endpackage

// File: rtl/cla_gp_unit.sv
module cla_gp_unit #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o
);
  assign gen_o  = x_in & y_in;
  assign prop_o = x_in ^ y_in;   // XOR form, shared with the sum stage
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
  parameter int unsigned SPAN = 4
) (
  input  logic [SPAN-1:0] gen_i,
  input  logic [SPAN-1:0] prop_i,
  input  logic            c0_i,
  output logic [SPAN:1]   carry_o
);
  import cla_pkg::*;
  cla_vec_t g_ext, p_ext;

  always_comb begin
    g_ext = '0;
    p_ext = '0;
    g_ext[SPAN-1:0] = gen_i;
    p_ext[SPAN-1:0] = prop_i;
  end

  for (genvar i = 0; i < SPAN; i++) begin : g_carry
    assign carry_o[i+1] = cla_sop(g_ext, p_ext, c0_i, i, 1'b1);
  end
endmodule

// File: rtl/cla_block_unit.sv
module cla_block_unit #(
  parameter int unsigned SPAN = 4
) (
  input  logic [SPAN-1:0] gen_i,
  input  logic [SPAN-1:0] prop_i,
  input  logic            c0_i,
  output logic [SPAN-1:1] carry_o,
  output logic            blk_gen_o,
  output logic            blk_prop_o
);
  import cla_pkg::*;
  cla_vec_t g_ext, p_ext;

  always_comb begin
    g_ext = '0;
    p_ext = '0;
    g_ext[SPAN-1:0] = gen_i;
    p_ext[SPAN-1:0] = prop_i;
  end

  for (genvar i = 0; i < SPAN-1; i++) begin : g_inner
    assign carry_o[i+1] = cla_sop(g_ext, p_ext, c0_i, i, 1'b1);
  end

  // Block terms exclude the block's own carry input.
  assign blk_gen_o  = cla_sop(g_ext, p_ext, 1'b0, SPAN-1, 1'b0);
  assign blk_prop_o = &prop_i;
endmodule

// File: rtl/cla_sum_unit.sv
module cla_sum_unit #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o
);
  assign sum_o = prop_i ^ carry_i;
endmodule

// File: rtl/cla_adder2.sv
module cla_adder2 #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned BLK   = 4
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_out
);
  localparam int unsigned NBLK = WIDTH / BLK;

  logic [WIDTH-1:0] gen_v, prop_v;
  logic [WIDTH:0]   carry_v;   // carry_v[i] feeds sum bit i

  cla_gp_unit #(.WIDTH(WIDTH)) u_gp (
    .x_in(x_in), .y_in(y_in), .gen_o(gen_v), .prop_o(prop_v)
  );

  assign carry_v[0] = c_in;

  if (NBLK == 1) begin : g_single
    // One lookahead unit covers the whole word.
    cla_carry_unit #(.SPAN(WIDTH)) u_cu (
      .gen_i(gen_v), .prop_i(prop_v), .c0_i(c_in), .carry_o(carry_v[WIDTH:1])
    );
  end else begin : g_two
    logic [NBLK-1:0] bg_v, bp_v;
    logic [NBLK:1]   bc_v;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
      cla_block_unit #(.SPAN(BLK)) u_blk (
        .gen_i     (gen_v[b*BLK +: BLK]),
        .prop_i    (prop_v[b*BLK +: BLK]),
        .c0_i      (carry_v[b*BLK]),
        .carry_o   (carry_v[b*BLK+BLK-1 : b*BLK+1]),
        .blk_gen_o (bg_v[b]),
        .blk_prop_o(bp_v[b])
      );
      assign carry_v[(b+1)*BLK] = bc_v[b+1];
    end

    // Second level: block carry inputs and the final carry.
    cla_carry_unit #(.SPAN(NBLK)) u_top (
      .gen_i(bg_v), .prop_i(bp_v), .c0_i(c_in), .carry_o(bc_v)
    );
  end

  cla_sum_unit #(.WIDTH(WIDTH)) u_sum (
    .prop_i(prop_v), .carry_i(carry_v[WIDTH-1:0]), .sum_o(sum_o)
  );

  assign c_out = carry_v[WIDTH];
endmodule

// File: rtl/cla_adder2_chk.sv
module cla_adder2_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] x_in,
  input logic [WIDTH-1:0] y_in,
  input logic             c_in,
  input logic [WIDTH-1:0] sum_o,
  input logic             c_out
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, c_in};

  always_comb begin
    // R1: arithmetic result
    p_sum_match_r1: assert ({c_out, sum_o} == ref_total);
    // R2: full-length chain from an increment of all ones
    if (&x_in && y_in == '0 && c_in)
      p_full_chain_r2: assert (c_out && sum_o == '0);
    // R3: every position propagates
    if (y_in == ~x_in)
      p_all_prop_r3: assert (c_out == c_in && sum_o == {WIDTH{~c_in}});
    // R4: zero operands
    if (x_in == '0 && y_in == '0)
      p_zero_ops_r4: assert (!c_out && sum_o == WIDTH'(c_in));
  end
endmodule

bind cla_adder2 cla_adder2_chk #(.WIDTH(WIDTH)) u_chk (
  .x_in(x_in), .y_in(y_in), .c_in(c_in), .sum_o(sum_o), .c_out(c_out)
);

// File: tb/cla_adder2_test.sv
module cla_adder2_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic clk;
  logic [15:0] x, y;
  logic        ci;
  logic [15:0] s;
  logic        co;
  logic [3:0]  x4, y4;
  logic        ci4;
  logic [3:0]  s4;
  logic        co4;
  int checks = 0;
  int fails  = 0;

  cla_adder2 uut (.x_in(x), .y_in(y), .c_in(ci), .sum_o(s), .c_out(co));
  cla_adder2 #(.WIDTH(4), .BLK(4)) uut4 (
    .x_in(x4), .y_in(y4), .c_in(ci4), .sum_o(s4), .c_out(co4));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Drive on the falling edge, check on the rising edge.
  task automatic add16(input logic [15:0] a, input logic [15:0] b,
                       input logic c, input string req);
    int unsigned exp;
    @(negedge clk);
    x = a; y = b; ci = c;
    @(posedge clk);
    exp = int'(a) + int'(b) + int'(c);
    checks++;
    if ({co, s} !== exp[16:0]) begin
      fails++;
      $display("FAIL %s: %h+%h+%b got %h expected %h", req, a, b, c, {co, s}, exp[16:0]);
    end
  endtask

  task automatic add4(input logic [3:0] a, input logic [3:0] b, input logic c);
    int unsigned exp;
    @(negedge clk);
    x4 = a; y4 = b; ci4 = c;
    @(posedge clk);
    exp = int'(a) + int'(b) + int'(c);
    checks++;
    if ({co4, s4} !== exp[4:0]) begin
      fails++;
      $display("FAIL R7: %h+%h+%b got %h expected %h", a, b, c, {co4, s4}, exp[4:0]);
    end
  endtask

  initial begin
    x = '0; y = '0; ci = 1'b0; x4 = '0; y4 = '0; ci4 = 1'b0;
    // R4 / R8: all-zero state, outputs follow inputs with no stored state
    add16(16'h0000, 16'h0000, 1'b0, "R4");
    add16(16'h0000, 16'h0000, 1'b1, "R4");
    // R2: full carry chain
    add16(16'hFFFF, 16'h0000, 1'b1, "R2");
    add16(16'hFFFF, 16'h0001, 1'b0, "R2");
    add16(16'hFFFF, 16'hFFFF, 1'b1, "R2");
    // R3: inverse operands, both carry values
    add16(16'h1234, 16'hEDCB, 1'b0, "R3");
    add16(16'h1234, 16'hEDCB, 1'b1, "R3");
    add16(16'h0000, 16'hFFFF, 1'b1, "R3");
    // R5: generated carry at each block top bit
    for (int k = 0; k < 4; k++) begin
      add16(16'h0008 << (4*k), 16'h0008 << (4*k), 1'b0, "R5");
      add16(16'h0007 << (4*k), 16'h0001 << (4*k), 1'b0, "R5");
    end
    // R6: alternating patterns
    add16(16'hAAAA, 16'h5555, 1'b0, "R6");
    add16(16'hAAAA, 16'hAAAA, 1'b0, "R6");
    add16(16'h5555, 16'h5555, 1'b1, "R6");
    add16(16'hAAAA, 16'h5555, 1'b1, "R6");
    // R8: back-to-back changes settle every half period
    add16(16'hFFFF, 16'h0000, 1'b1, "R8");
    add16(16'h0000, 16'h0000, 1'b0, "R8");
    // R1: random operands
    for (int n = 0; n < 3000; n++)
      add16(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    // R7: exhaustive single-level build
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++)
          add4(4'(a), 4'(b), 1'(c));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got %0d checks expected completion", checks);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule